// File: doc/BRIEF.md
# Prefix-Tree Magnitude Comparator

This block compares two unsigned operands of a parameterised width (16, 32 or 64 bits in normal use, any multiple of four) and reports whether the first is equal to, greater than or less than the second. It is purely combinational. There is no subtraction and no bit-serial ripple. The block scans for differences from the most significant end by way of a bounded fan-in prefix tree.

The resolution stage takes the bitwise XOR of the operands. A "difference above" prefix signal is built for every bit. This uses four-bit groups and then a logarithmic scan across the groups. The prefix signals drive one 2:1 mux per bit. Each mux passes the operand bit pair only at the highest differing position and a hardwired zero pair everywhere else. This yields two one-hot-or-zero buses.

The decision stage reduces each bus with its own OR tree, again grouped by four. It then derives the three flags from the two results. The buses are also driven out as debug outputs.

Top module: `prefix_mag_cmp`

## Requirements
- R1: At every bit position where opA and opB hold the same value, both leftBus and rightBus carry 0.
- R2: At the position that is marked, leftBus bit k equals opA bit k and rightBus bit k equals opB bit k. A set leftBus bit therefore means opA has 1 and opB has 0 there, and a set rightBus bit means the reverse. Bus bit k corresponds to operand bit k, with bit 0 as the LSB.
- R3: The marked position is the highest index where the operands differ. Every lower position is 00 on both buses, whatever the operand bits there are.
- R4: When opA equals opB, both buses are entirely zero. When they differ, some bus bit is set.
- R5: Across the 2×WIDTH bus bits, at most one bit is 1.
- R6: aGtB is 1 exactly when opA is greater than opB as an unsigned number. This holds also when the only difference lies in the MSB or in the LSB.
- R7: aLtB is 1 exactly when opA is less than opB as an unsigned number. For example, with opA=0x5D and opB=0x69 at width 8, only bit 5 is marked, on rightBus.
- R8: aEqB is 1 exactly when opA equals opB. This includes the all-zero operand pair.
- R9: Exactly one of aEqB, aGtB and aLtB is 1 for every input pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| aEqB | output | 1 | Operands equal |
| aGtB | output | 1 | opA greater than opB |
| aLtB | output | 1 | opA less than opB |
| leftBus | output | WIDTH | opA bit at the highest differing position, zero elsewhere |
| rightBus | output | WIDTH | opB bit at the highest differing position, zero elsewhere |

## Verification
The block holds no state, so a wrong kill strobe shows at the ports in the same evaluation as the inputs that exposed it. A missing "difference above" term lets a second, lower bit through onto a bus. A stuck-high term erases the mark, so a differing pair looks equal. Either fault breaks the one-hot bus shape or the flag agreement with an unsigned compare at once. Coverage comes from every pair at width 8, together with wide pairs that differ only at the MSB, only at the LSB, at one random bit, or below a shared random prefix.

// File: rtl/prefix_cmp_pkg.sv
package prefix_cmp_pkg;

  // Bits per prefix group; bounds the fan-in of every OR gate in the tree.
  localparam int GRP_BITS = 4;

  // Decision flags handed from the decision stage to the top.
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmpFlags_t;

endpackage

// File: rtl/pfx_kill_ctrl.sv
// Control half: builds the per-bit select strobe that is true only at the
// highest differing position (difference here, none above).
module pfx_kill_ctrl
  import prefix_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] diff,
  output logic [WIDTH-1:0] selFirst
);

  localparam int NG = WIDTH / GRP_BITS;
  localparam int LV = (NG > 1) ? $clog2(NG) : 0;

  // scan level l, group g: any difference in groups g+1 .. g+2^l
  logic [(LV+1)*NG-1:0] scan;
  logic [WIDTH-1:0]     inAbove;

  generate
    if (WIDTH % GRP_BITS != 0) begin : g_bad_width
      $error("prefix comparator WIDTH must be a multiple of 4");
    end

    // Seed: each group sees the OR of the group directly above it.
    for (genvar g = 0; g < NG; g++) begin : g_seed
      if (g < NG - 1) begin : g_hi
        assign scan[g] = |diff[GRP_BITS*(g+1) +: GRP_BITS];
      end else begin : g_top
        assign scan[g] = 1'b0;
      end
    end

    // Logarithmic suffix scan across groups, fan-in two per node.
    for (genvar l = 0; l < LV; l++) begin : g_lvl
      for (genvar g = 0; g < NG; g++) begin : g_node
        if (g + (1 << l) < NG) begin : g_pair
          assign scan[(l+1)*NG + g] = scan[l*NG + g] | scan[l*NG + g + (1 << l)];
        end else begin : g_pass
          assign scan[(l+1)*NG + g] = scan[l*NG + g];
        end
      end
    end

    // Inside each group: OR of the more significant bits of that group.
    for (genvar g = 0; g < NG; g++) begin : g_grp
      for (genvar i = 0; i < GRP_BITS; i++) begin : g_bit
        localparam int K = g*GRP_BITS + i;
        if (i == GRP_BITS - 1) begin : g_msb
          assign inAbove[K] = 1'b0;
        end else begin : g_rest
          assign inAbove[K] = |diff[g*GRP_BITS + GRP_BITS - 1 : K + 1];
        end
        assign selFirst[K] = diff[K] & ~inAbove[K] & ~scan[LV*NG + g];
      end
    end
  endgenerate

endmodule

// File: rtl/pfx_bus_dp.sv
// Datapath half: bit differences and the per-bit 2:1 muxes onto the buses.
module pfx_bus_dp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] selFirst,
  output logic [WIDTH-1:0] diff,
  output logic [WIDTH-1:0] leftBus,
  output logic [WIDTH-1:0] rightBus
);

  assign diff = opA ^ opB;

  generate
    for (genvar k = 0; k < WIDTH; k++) begin : g_mux
      // One input is the operand pair, the other the constant pair 00.
      assign leftBus[k]  = selFirst[k] ? opA[k] : 1'b0;
      assign rightBus[k] = selFirst[k] ? opB[k] : 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pfx_or_tree.sv
// Bounded fan-in OR reduction: four-bit groups, then a binary tree.
module pfx_or_tree
  import prefix_cmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] bits,
  output logic         any
);

  localparam int NG = W / GRP_BITS;
  localparam int LV = (NG > 1) ? $clog2(NG) : 0;

  function automatic int nodesAt(input int l);
    return (NG + (1 << l) - 1) >> l;
  endfunction

  generate
    for (genvar l = 0; l <= LV; l++) begin : g_lvl
      logic [nodesAt(l)-1:0] node;
      if (l == 0) begin : g_base
        for (genvar g = 0; g < NG; g++) begin : g_leaf
          assign node[g] = |bits[GRP_BITS*g +: GRP_BITS];
        end
      end else begin : g_up
        for (genvar g = 0; g < nodesAt(l); g++) begin : g_node
          if (2*g + 1 < nodesAt(l-1)) begin : g_pair
            assign node[g] = g_lvl[l-1].node[2*g] | g_lvl[l-1].node[2*g+1];
          end else begin : g_pass
            assign node[g] = g_lvl[l-1].node[2*g];
          end
        end
      end
    end
  endgenerate

  assign any = g_lvl[LV].node[0];

endmodule

// File: rtl/pfx_decide.sv
// Decision stage: separate OR networks over the two buses.
module pfx_decide
  import prefix_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] leftBus,
  input  logic [WIDTH-1:0] rightBus,
  output cmpFlags_t        flags
);

  logic leftAny;
  logic rightAny;

  pfx_or_tree #(.W(WIDTH)) u_orLeft  (.bits(leftBus),  .any(leftAny));
  pfx_or_tree #(.W(WIDTH)) u_orRight (.bits(rightBus), .any(rightAny));

  assign flags.gt = leftAny;
  assign flags.lt = rightAny;
  assign flags.eq = ~(leftAny | rightAny);

endmodule

// File: rtl/prefix_mag_cmp.sv
module prefix_mag_cmp
  import prefix_cmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             aEqB,
  output logic             aGtB,
  output logic             aLtB,
  output logic [WIDTH-1:0] leftBus,
  output logic [WIDTH-1:0] rightBus
);

  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] selFirst;
  cmpFlags_t        flags;

  pfx_bus_dp #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .selFirst (selFirst),
    .diff     (diff),
    .leftBus  (leftBus),
    .rightBus (rightBus)
  );

  pfx_kill_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .diff     (diff),
    .selFirst (selFirst)
  );

  pfx_decide #(.WIDTH(WIDTH)) u_dec (
    .leftBus  (leftBus),
    .rightBus (rightBus),
    .flags    (flags)
  );

  assign aEqB = flags.eq;
  assign aGtB = flags.gt;
  assign aLtB = flags.lt;

endmodule

// File: rtl/prefix_mag_cmp_chk.sv
module prefix_mag_cmp_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             aEqB,
  input logic             aGtB,
  input logic             aLtB,
  input logic [WIDTH-1:0] leftBus,
  input logic [WIDTH-1:0] rightBus
);

  logic [WIDTH-1:0] hot;
  logic [WIDTH:0]   hotUp;

  assign hot   = leftBus | rightBus;
  assign hotUp = {hot, 1'b0};

  always_comb begin
    AST_FLAG_ONEHOT: assert ($countones({aEqB, aGtB, aLtB}) == 1) else $error("flags not one-hot"); // R9
    AST_BUS_ONEHOT0: assert ($onehot0({leftBus, rightBus})) else $error("more than one bus bit"); // R5
    AST_AGREE_QUIET: assert ((hot & ~(opA ^ opB)) == '0) else $error("bus bit at agreeing position"); // R1
    AST_LEFT_CODE: assert ((leftBus & ~(opA & ~opB)) == '0) else $error("left bus code wrong"); // R2
    AST_RIGHT_CODE: assert ((rightBus & ~(opB & ~opA)) == '0) else $error("right bus code wrong"); // R2
    AST_MARK_HIGHEST: assert (hot == '0 || (({1'b0, opA ^ opB} & ~(hotUp - 1'b1)) == '0)) else $error("mark not at highest difference"); // R3
    AST_EQUAL_QUIET: assert ((opA == opB) == (hot == '0)) else $error("bus activity disagrees with equality"); // R4
    AST_GT_MATCH: assert (aGtB == (opA > opB)) else $error("greater flag wrong"); // R6
    AST_LT_MATCH: assert (aLtB == (opA < opB)) else $error("less flag wrong"); // R7
    AST_EQ_MATCH: assert (aEqB == (opA == opB)) else $error("equal flag wrong"); // R8
  end

endmodule

bind prefix_mag_cmp prefix_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .aEqB     (aEqB),
  .aGtB     (aGtB),
  .aLtB     (aLtB),
  .leftBus  (leftBus),
  .rightBus (rightBus)
);

// File: tb/prefix_mag_cmp_test.sv
`timescale 1ns/1ps
module prefix_mag_cmp_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  int nChecks = 0;
  int nFail   = 0;

  logic [63:0] drvA = '0;
  logic [63:0] drvB = '0;

  logic       eq8, gt8, lt8;
  logic [7:0] left8, right8;
  logic        eq64, gt64, lt64;
  logic [63:0] left64, right64;

  prefix_mag_cmp #(.WIDTH(8)) uut (
    .opA(drvA[7:0]), .opB(drvB[7:0]),
    .aEqB(eq8), .aGtB(gt8), .aLtB(lt8),
    .leftBus(left8), .rightBus(right8)
  );

  prefix_mag_cmp #(.WIDTH(64)) uutWide (
    .opA(drvA), .opB(drvB),
    .aEqB(eq64), .aGtB(gt64), .aLtB(lt64),
    .leftBus(left64), .rightBus(right64)
  );

  typedef struct {
    string       tag;
    logic        eq8, gt8, lt8;
    logic [63:0] lb8, rb8;
    logic        eq64, gt64, lt64;
    logic [63:0] lb64, rb64;
  } item_t;

  item_t q[$];
  item_t cur;

  function automatic void refModel(input logic [63:0] a, input logic [63:0] b, input int w,
                                   output logic eq, output logic gt, output logic lt,
                                   output logic [63:0] lb, output logic [63:0] rb);
    logic [63:0] m;
    logic [63:0] am;
    logic [63:0] bm;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    am = a & m;
    bm = b & m;
    eq = (am == bm);
    gt = (am > bm);
    lt = (am < bm);
    lb = '0;
    rb = '0;
    for (int k = w - 1; k >= 0; k--) begin
      if (am[k] != bm[k]) begin
        lb[k] = am[k];
        rb[k] = bm[k];
        break;
      end
    end
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Driver: apply a pair after a rising edge and queue what must come out.
  task automatic drive(input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(posedge clk);
    drvA = a;
    drvB = b;
    it.tag = tag;
    refModel(a, b, 8,  it.eq8,  it.gt8,  it.lt8,  it.lb8,  it.rb8);
    refModel(a, b, 64, it.eq64, it.gt64, it.lt64, it.lb64, it.rb64);
    q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, once the combinational paths settle.
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      cur = q.pop_front();
      chk(eq8 == cur.eq8, {"R8 eq w8 ", cur.tag}, 64'(eq8), 64'(cur.eq8));
      chk(gt8 == cur.gt8, {"R6 gt w8 ", cur.tag}, 64'(gt8), 64'(cur.gt8));
      chk(lt8 == cur.lt8, {"R7 lt w8 ", cur.tag}, 64'(lt8), 64'(cur.lt8));
      chk($countones({eq8, gt8, lt8}) == 1, {"R9 flags w8 ", cur.tag}, 64'({eq8, gt8, lt8}), 64'd1);
      chk({56'd0, left8} == cur.lb8, {"R1 R2 R3 R4 left w8 ", cur.tag}, {56'd0, left8}, cur.lb8);
      chk({56'd0, right8} == cur.rb8, {"R1 R2 R3 R4 right w8 ", cur.tag}, {56'd0, right8}, cur.rb8);
      chk($countones({left8, right8}) <= 1, {"R5 bus w8 ", cur.tag}, 64'({left8, right8}), 64'd0);
      chk(eq64 == cur.eq64, {"R8 eq w64 ", cur.tag}, 64'(eq64), 64'(cur.eq64));
      chk(gt64 == cur.gt64, {"R6 gt w64 ", cur.tag}, 64'(gt64), 64'(cur.gt64));
      chk(lt64 == cur.lt64, {"R7 lt w64 ", cur.tag}, 64'(lt64), 64'(cur.lt64));
      chk($countones({eq64, gt64, lt64}) == 1, {"R9 flags w64 ", cur.tag}, 64'({eq64, gt64, lt64}), 64'd1);
      chk(left64 == cur.lb64, {"R1 R2 R3 R4 left w64 ", cur.tag}, left64, cur.lb64);
      chk(right64 == cur.rb64, {"R1 R2 R3 R4 right w64 ", cur.tag}, right64, cur.rb64);
      chk($countones({left64, right64}) <= 1, {"R5 bus w64 ", cur.tag}, left64 | right64, 64'd0);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", q.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    logic [63:0] r;
    logic [63:0] s;
    int p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Idle state with zero operands (R8, R4).
    chk(eq8 == 1'b1 && gt8 == 1'b0 && lt8 == 1'b0, "R8 idle w8", 64'({eq8, gt8, lt8}), 64'b100);
    chk(eq64 == 1'b1 && left64 == '0 && right64 == '0, "R4 idle w64", left64 | right64, 64'd0);
    rst = 1'b0;

    // Worked example: 0x5D vs 0x69 must mark bit 5 on the right bus (R7).
    drive(64'h5D, 64'h69, "example");

    // Every pair at width 8; the wide instance sees the pattern replicated.
    for (int i = 0; i < 65536; i++) begin
      drive({8{i[15:8]}}, {8{i[7:0]}}, "exhaustive");
    end

    for (int n = 0; n < 400; n++) begin
      r = {$urandom(), $urandom()};
      s = {$urandom(), $urandom()};
      p = int'($urandom() % 64);
      drive(r, r, "equal");
      drive(r, r ^ (64'd1 << 63), "msb-only");
      drive(r, r ^ 64'd1, "lsb-only");
      drive(r, r ^ (64'd1 << p), "single-bit");
      drive(r, (r & ~((64'd1 << p) - 64'd1)) | (s & ((64'd1 << p) - 64'd1)), "shared-prefix");
      drive(r, s, "random");
    end

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule